// File: doc/BRIEF.md
# I2C Target Engine with Clock Stretching

This block is the target (slave) side of an I2C bus. It watches the open-drain SCL and SDA lines through a two-flop synchronizer and finds start and stop conditions. It shifts in the first byte after a start and compares its upper seven bits with a programmed 7-bit own address. On a match it acknowledges. If the direction bit asks for a write, it accepts data bytes. If it asks for a read, it supplies data bytes, most significant bit first.

A single data register is shared between the host side and the bus. The engine pulls SCL low while it waits for the host. For a received byte, it waits until the host reads the register. For a byte to send, it waits until the host writes the register. A receive-request flag, a transmit-request flag and a first-byte marker show what is pending. Three interrupt sources report start, stop and data events. Each source has a raw bit, a mask bit, a masked bit and a write-1-to-clear strobe. Both bus lines are driven only as pull-low enables.

Top module: `i2ct_target`

## Requirements
- R1: After a start, the engine pulls SDA low during the ninth clock exactly when the received bits 7..1 of the first byte equal `own_addr_i`. For any other address it leaves SDA released and ignores the rest of the transfer.
- R2: While `dev_active_i` is 0, the engine never pulls SCL or SDA and raises no interrupt, whatever happens on the bus.
- R3: In a write transfer (first-byte bit 0 = 0), each received data byte is placed in the data register and sets `stat_rreq_o`. The engine holds SCL low until a `dr_rd_i` strobe, which clears `stat_rreq_o`. It then acknowledges the byte by pulling SDA low on the ninth clock.
- R4: `stat_first_o` is 1 together with `stat_rreq_o` only for the first data byte after the address. A `dr_rd_i` strobe clears it.
- R5: In a read transfer (first-byte bit 0 = 1), `stat_treq_o` is raised and SCL is held low until a `dr_wr_i` strobe. The written byte is then sent MSB first.
- R6: A controller acknowledge (SDA low on the ninth clock of a sent byte) raises `stat_treq_o` and stretches again for the next byte. A controller NACK ends the read: no further stretch and no transmit request.
- R7: Interrupt bit positions are bit 0 = start seen, bit 1 = stop seen and bit 2 = data received or requested. A raw bit is set by its event.
- R8: `irq_masked_o` equals `irq_raw_o` AND `irq_mask_o`, and `irq_o` is the OR of the masked bits. `mask_wr_i` loads the mask.
- R9: A `clr_wr_i` strobe clears every raw bit whose `clr_wdata_i` bit is 1. Bits written as 0 are unchanged.
- R10: `dr_rdata_o` returns the last value written by the host or received from the bus, whichever came last.
- R11: After reset, no line is pulled, all status, interrupt and mask bits are 0, and the data register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| scl_pull_o | output | 1 | Pull SCL low (clock stretch) |
| sda_pull_o | output | 1 | Pull SDA low (ACK or data 0) |
| own_addr_i | input | 7 | Programmed own address |
| dev_active_i | input | 1 | Enables bus participation |
| dr_wr_i | input | 1 | Host write strobe for the data register |
| dr_wdata_i | input | 8 | Host write data |
| dr_rd_i | input | 1 | Host read strobe for the data register |
| dr_rdata_o | output | 8 | Data register contents |
| stat_rreq_o | output | 1 | Received byte waiting for the host |
| stat_treq_o | output | 1 | Byte to send requested from the host |
| stat_first_o | output | 1 | Waiting byte is the first after the address |
| mask_wr_i | input | 1 | Load the interrupt mask |
| mask_wdata_i | input | 3 | New interrupt mask |
| clr_wr_i | input | 1 | Interrupt clear strobe |
| clr_wdata_i | input | 3 | Write-1-to-clear bits |
| irq_raw_o | output | 3 | Raw interrupt status |
| irq_mask_o | output | 3 | Current mask |
| irq_masked_o | output | 3 | Masked interrupt status |
| irq_o | output | 1 | Combined interrupt line |

## Verification
The bench acts as the bus controller. It sweeps all 128 addresses against one own address. A wrong comparator would acknowledge a neighbour or stay silent for its own address.

During the write and read transfers, the bench releases SCL and checks that the line stays low until the host strobe. An engine that forgets to stretch would let the bus run on with a stale byte. The first-byte marker is checked on the first and later bytes, since a marker that never cleared would mislabel every byte.

The bench ends a read with a NACK to catch an engine that keeps stretching after the controller has finished. It also runs a transfer with the engine disabled to catch acknowledges or interrupts that leak through. Clears written as zero and partial masks are checked bit by bit, because an interrupt block that swapped bit positions or ignored the clear data would fail there.

// File: rtl/i2ct_pkg.sv
// Shared types for the I2C target engine.
// Assumes 7-bit addressing and one data byte per bus transfer step.
package i2ct_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // not addressed, lines released
        ST_ADDR,   // shifting in the address byte
        ST_AACK,   // acknowledging own address
        ST_RX,     // shifting in a data byte
        ST_RACK,   // acknowledging a data byte
        ST_TX,     // shifting out a data byte
        ST_TACK    // sampling the controller's acknowledge
    } tgt_state_e;

    localparam int NUM_IRQ   = 3;
    localparam int IRQ_START = 0;
    localparam int IRQ_STOP  = 1;
    localparam int IRQ_DATA  = 2;
endpackage

// File: rtl/i2ct_sync.sv
// Multi-stage synchronizer for asynchronous bus lines.
// Assumes an idle-high bus, so every stage resets to 1.
module i2ct_sync #(
    parameter int STAGES = 2,
    parameter int LINES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] d_in,
    output logic [LINES-1:0] q_out
);
    genvar g;
    generate
        for (g = 0; g < LINES; g++) begin : g_line
            logic [STAGES-1:0] chain;
            // shift each line through its own flop chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], d_in[g]};
            end
            assign q_out[g] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/i2ct_bus_events.sv
// Edge and bus-condition detector on synchronized SCL/SDA.
// Start: SDA falls while SCL stays high. Stop: SDA rises while SCL stays high.
module i2ct_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q, sda_q;

    // remember previous sampled levels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2ct_irq.sv
// Interrupt sources with raw, mask, masked views and write-1-to-clear.
// A set event in the same cycle as its clear wins over the clear.
module i2ct_irq #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         mask_wr_i,
    input  logic [N-1:0] mask_wdata_i,
    input  logic         clr_wr_i,
    input  logic [N-1:0] clr_wdata_i,
    output logic [N-1:0] raw_o,
    output logic [N-1:0] mask_o,
    output logic [N-1:0] masked_o,
    output logic         irq_o
);
    logic [N-1:0] clr_vec;
    assign clr_vec = clr_wr_i ? clr_wdata_i : '0;

    // raw status and mask registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_o  <= '0;
            mask_o <= '0;
        end else begin
            raw_o <= (raw_o & ~clr_vec) | set_i;
            if (mask_wr_i) mask_o <= mask_wdata_i;
        end
    end

    assign masked_o = raw_o & mask_o;
    assign irq_o    = |masked_o;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_chk
            AST_CLEAR_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_wr_i && clr_wdata_i[g] && !set_i[g]) |=> !raw_o[g]); // R9
            AST_EVENT_SETS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
                set_i[g] |=> raw_o[g]); // R7
        end
    endgenerate
endmodule

// File: rtl/i2ct_target.sv
// I2C target engine: address match, ACK, byte shifting, clock stretching.
// Assumes DATA_W = ADDR_W + 1 (address byte carries the direction bit in bit 0).
module i2ct_target
    import i2ct_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_pull_o,
    output logic              sda_pull_o,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic              dev_active_i,
    input  logic              dr_wr_i,
    input  logic [DATA_W-1:0] dr_wdata_i,
    input  logic              dr_rd_i,
    output logic [DATA_W-1:0] dr_rdata_o,
    output logic              stat_rreq_o,
    output logic              stat_treq_o,
    output logic              stat_first_o,
    input  logic              mask_wr_i,
    input  logic [NUM_IRQ-1:0] mask_wdata_i,
    input  logic              clr_wr_i,
    input  logic [NUM_IRQ-1:0] clr_wdata_i,
    output logic [NUM_IRQ-1:0] irq_raw_o,
    output logic [NUM_IRQ-1:0] irq_mask_o,
    output logic [NUM_IRQ-1:0] irq_masked_o,
    output logic              irq_o
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    logic scl_s, sda_s;
    logic scl_rise, scl_fall, start_det, stop_det;
    tgt_state_e state;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] rx_sh, tx_sh, dreg;
    logic hold, rreq, treq, first, first_pend, got8, hit, rw, nack;
    logic edge_ok, addr_hit, ev_rreq, ev_data;
    logic [NUM_IRQ-1:0] irq_set;

    i2ct_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in({sda_i, scl_i}), .q_out({sda_s, scl_s}));

    i2ct_bus_events u_ev (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det));

    // event decode shared by the state machine and the interrupt block
    always_comb begin
        edge_ok  = dev_active_i && !start_det && !stop_det;
        addr_hit = (rx_sh[ADDR_W-1:0] == own_addr_i);
        ev_rreq  = edge_ok && scl_rise && (state == ST_RX) && (cnt == LAST_BIT);
        ev_data  = ev_rreq
                 || (edge_ok && scl_rise && (state == ST_ADDR) && (cnt == LAST_BIT) && addr_hit && sda_s)
                 || (edge_ok && scl_fall && (state == ST_TACK) && !nack);
        irq_set            = '0;
        irq_set[IRQ_START] = dev_active_i && start_det;
        irq_set[IRQ_STOP]  = dev_active_i && stop_det;
        irq_set[IRQ_DATA]  = ev_data;
    end

    // bit engine, handshake flags and clock-stretch control
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE; cnt <= '0; rx_sh <= '0; tx_sh <= '0; dreg <= '0;
            hold <= 1'b0; rreq <= 1'b0; treq <= 1'b0; first <= 1'b0;
            first_pend <= 1'b0; got8 <= 1'b0; hit <= 1'b0; rw <= 1'b0; nack <= 1'b0;
        end else begin
            if (dr_wr_i) dreg <= dr_wdata_i;
            if (!dev_active_i) begin
                state <= ST_IDLE; hold <= 1'b0; treq <= 1'b0; got8 <= 1'b0;
            end else begin
                if (dr_wr_i && treq) begin
                    tx_sh <= dr_wdata_i;
                    treq  <= 1'b0;
                end
                if (hold && state == ST_TX && !treq) hold <= 1'b0;
                if (dr_rd_i) begin
                    rreq  <= 1'b0;
                    first <= 1'b0;
                    if (state == ST_RACK) hold <= 1'b0;
                end
                if (start_det) begin
                    state <= ST_ADDR; cnt <= '0; got8 <= 1'b0; hold <= 1'b0; treq <= 1'b0;
                end else if (stop_det) begin
                    state <= ST_IDLE; hold <= 1'b0; treq <= 1'b0;
                end else if (scl_rise) begin
                    if (state == ST_ADDR || state == ST_RX) begin
                        rx_sh <= {rx_sh[DATA_W-2:0], sda_s};
                        cnt   <= cnt + 1'b1;
                        if (cnt == LAST_BIT) begin
                            got8 <= 1'b1;
                            if (state == ST_ADDR) begin
                                hit <= addr_hit;
                                rw  <= sda_s;
                                if (addr_hit && sda_s) treq <= 1'b1;
                            end else begin
                                dreg  <= {rx_sh[DATA_W-2:0], sda_s};
                                rreq  <= 1'b1;
                                first <= first_pend;
                            end
                        end
                    end else if (state == ST_TACK) begin
                        nack <= sda_s;
                    end
                end else if (scl_fall) begin
                    case (state)
                        ST_ADDR: if (got8) begin
                            got8  <= 1'b0;
                            state <= hit ? ST_AACK : ST_IDLE;
                        end
                        ST_AACK: begin
                            cnt <= '0;
                            if (rw) begin
                                state <= ST_TX;
                                hold  <= treq && !dr_wr_i;
                            end else begin
                                state      <= ST_RX;
                                first_pend <= 1'b1;
                            end
                        end
                        ST_RX: if (got8) begin
                            got8  <= 1'b0;
                            state <= ST_RACK;
                            hold  <= rreq && !dr_rd_i;
                        end
                        ST_RACK: begin
                            state      <= ST_RX;
                            cnt        <= '0;
                            first_pend <= 1'b0;
                        end
                        ST_TX: begin
                            if (cnt == LAST_BIT) state <= ST_TACK;
                            else begin
                                tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
                                cnt   <= cnt + 1'b1;
                            end
                        end
                        ST_TACK: begin
                            if (nack) state <= ST_IDLE;
                            else begin
                                state <= ST_TX; cnt <= '0; treq <= 1'b1; hold <= 1'b1;
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    assign scl_pull_o   = hold;
    assign sda_pull_o   = dev_active_i && ((state == ST_AACK) || (state == ST_RACK)
                          || (state == ST_TX && !treq && !tx_sh[DATA_W-1]));
    assign dr_rdata_o   = dreg;
    assign stat_rreq_o  = rreq;
    assign stat_treq_o  = treq;
    assign stat_first_o = first;

    i2ct_irq #(.N(NUM_IRQ)) u_irq (
        .clk(clk), .rst_n(rst_n), .set_i(irq_set),
        .mask_wr_i(mask_wr_i), .mask_wdata_i(mask_wdata_i),
        .clr_wr_i(clr_wr_i), .clr_wdata_i(clr_wdata_i),
        .raw_o(irq_raw_o), .mask_o(irq_mask_o), .masked_o(irq_masked_o), .irq_o(irq_o));

    AST_OFF_NO_PULL: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_active_i |=> (!scl_pull_o && !sda_pull_o)); // R2
    AST_FIRST_NEEDS_RREQ: assert property (@(posedge clk) disable iff (!rst_n)
        stat_first_o |-> stat_rreq_o); // R4
    AST_HOLD_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        scl_pull_o |-> (stat_treq_o || stat_rreq_o || state == ST_TX)); // R5
    AST_READ_DROPS_RREQ: assert property (@(posedge clk) disable iff (!rst_n)
        (dr_rd_i && dev_active_i && !ev_rreq) |=> !stat_rreq_o); // R3
endmodule

// File: tb/i2ct_target_tb.sv
// Bench acting as bus controller and host for the I2C target engine.
module i2ct_target_tb_top;
    localparam int H = 16;
    localparam logic [6:0] OWN = 7'h5A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tb_scl_low = 1'b0, tb_sda_low = 1'b0;
    logic scl_line, sda_line, scl_pull, sda_pull;
    logic dev_active = 1'b1;
    logic dr_wr = 1'b0, dr_rd = 1'b0;
    logic [7:0] dr_wdata = '0, dr_rdata;
    logic rreq, treq, first;
    logic mask_wr = 1'b0, clr_wr = 1'b0;
    logic [2:0] mask_wdata = '0, clr_wdata = '0;
    logic [2:0] raw, msk, masked;
    logic irq;
    int n_chk = 0, n_err = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    assign scl_line = ~(tb_scl_low | scl_pull);
    assign sda_line = ~(tb_sda_low | sda_pull);

    i2ct_target dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .scl_pull_o(scl_pull), .sda_pull_o(sda_pull), .own_addr_i(OWN),
        .dev_active_i(dev_active), .dr_wr_i(dr_wr), .dr_wdata_i(dr_wdata),
        .dr_rd_i(dr_rd), .dr_rdata_o(dr_rdata), .stat_rreq_o(rreq),
        .stat_treq_o(treq), .stat_first_o(first), .mask_wr_i(mask_wr),
        .mask_wdata_i(mask_wdata), .clr_wr_i(clr_wr), .clr_wdata_i(clr_wdata),
        .irq_raw_o(raw), .irq_mask_o(msk), .irq_masked_o(masked), .irq_o(irq));

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // release SCL, wait out any stretch, sample SDA mid-high, pull SCL low
    task automatic pulse(output logic seen);
        int n = 0;
        tb_scl_low = 1'b0;
        while (!scl_line && n < 2000) begin cyc(1); n++; end
        if (n >= 2000) chk("stretch timeout", 0, 1);
        cyc(H/2);
        seen = sda_line;
        cyc(H/2);
        tb_scl_low = 1'b1;
        cyc(H/2);
    endtask

    task automatic bus_start();
        tb_sda_low = 1'b0; tb_scl_low = 1'b0; cyc(H);
        tb_sda_low = 1'b1; cyc(H);
        tb_scl_low = 1'b1; cyc(H);
    endtask

    task automatic bus_stop();
        logic s;
        tb_sda_low = 1'b1; cyc(H);
        tb_scl_low = 1'b0;
        for (int n = 0; n < 2000 && !scl_line; n++) cyc(1);
        cyc(H);
        tb_sda_low = 1'b0; cyc(H);
        s = sda_line;
    endtask

    // send 8 bits MSB first, leave SDA released, SCL low
    task automatic send_bits(input logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            tb_sda_low = ~b[i]; cyc(2);
            pulse(s);
        end
        tb_sda_low = 1'b0; cyc(2);
    endtask

    task automatic host_read();
        dr_rd = 1'b1; cyc(1); dr_rd = 1'b0;
    endtask

    task automatic host_write(input logic [7:0] d);
        dr_wdata = d; dr_wr = 1'b1; cyc(1); dr_wr = 1'b0;
    endtask

    task automatic irq_clear(input logic [2:0] v);
        clr_wdata = v; clr_wr = 1'b1; cyc(1); clr_wr = 1'b0; cyc(1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic s;
        logic [7:0] wr_bytes [3];
        logic [7:0] rd_bytes [3];
        logic [7:0] got;
        wr_bytes[0] = 8'hA5; wr_bytes[1] = 8'h3C; wr_bytes[2] = 8'h0F;
        rd_bytes[0] = 8'hC3; rd_bytes[1] = 8'h7E; rd_bytes[2] = 8'h81;

        cyc(5); rst_n = 1'b1; cyc(2);
        // R11 reset state
        chk("R11 pulls", {scl_pull, sda_pull}, 0);
        chk("R11 status", {first, treq, rreq}, 0);
        chk("R11 irq", {irq, masked, msk, raw}, 0);
        chk("R11 data", dr_rdata, 0);

        // R1 sweep over all addresses, write direction
        for (int a = 0; a < 128; a++) begin
            bus_start();
            send_bits({7'(a), 1'b0});
            pulse(s);
            chk($sformatf("R1 ack addr %0h", a), !s, (a == OWN));
            bus_stop();
            irq_clear(3'b111);
        end

        // R3 R4 R10 write transfer with stretching
        bus_start();
        send_bits({OWN, 1'b0});
        pulse(s);
        chk("R1 own ack", !s, 1);
        for (int k = 0; k < 3; k++) begin
            send_bits(wr_bytes[k]);
            tb_scl_low = 1'b0; cyc(12);
            chk("R3 scl held", scl_line, 0);
            chk("R3 rreq", rreq, 1);
            chk("R4 first", first, (k == 0));
            chk("R10 rx data", dr_rdata, wr_bytes[k]);
            chk("R7 data raw", raw[2], 1);
            host_read();
            chk("R4 first cleared", first, 0);
            chk("R3 rreq cleared", rreq, 0);
            pulse(s);
            chk("R3 byte ack", !s, 1);
        end
        bus_stop();
        chk("R7 raw all", raw, 3'b111);
        chk("R10 last rx kept", dr_rdata, 8'h0F);

        // R9 clear semantics
        irq_clear(3'b000);
        chk("R9 zero clear", raw, 3'b111);
        irq_clear(3'b001);
        chk("R9 partial clear", raw, 3'b110);
        // R8 masking
        mask_wdata = 3'b100; mask_wr = 1'b1; cyc(1); mask_wr = 1'b0;
        chk("R8 mask", msk, 3'b100);
        chk("R8 masked", masked, 3'b100);
        chk("R8 irq on", irq, 1);
        mask_wdata = 3'b001; mask_wr = 1'b1; cyc(1); mask_wr = 1'b0;
        chk("R8 masked off", masked, 3'b000);
        chk("R8 irq off", irq, 0);
        irq_clear(3'b111);
        chk("R9 all cleared", raw, 3'b000);

        // R10 host write readback
        host_write(8'h99);
        chk("R10 host write", dr_rdata, 8'h99);

        // R5 R6 read transfer
        bus_start();
        send_bits({OWN, 1'b1});
        pulse(s);
        chk("R1 read ack", !s, 1);
        for (int k = 0; k < 3; k++) begin
            tb_scl_low = 1'b0; cyc(12);
            chk("R5 scl held", scl_line, 0);
            chk("R5 treq", treq, 1);
            tb_scl_low = 1'b1;
            host_write(rd_bytes[k]);
            cyc(2);
            got = '0;
            for (int i = 0; i < 8; i++) begin
                pulse(s);
                got = {got[6:0], s};
            end
            chk("R5 tx byte", got, rd_bytes[k]);
            tb_sda_low = (k < 2); cyc(2);
            pulse(s);
            tb_sda_low = 1'b0; cyc(2);
        end
        tb_scl_low = 1'b0; cyc(12);
        chk("R6 no stretch after nack", scl_line, 1);
        chk("R6 no treq after nack", treq, 0);
        tb_scl_low = 1'b1; cyc(H);
        bus_stop();
        chk("R10 last tx kept", dr_rdata, 8'h81);
        irq_clear(3'b111);

        // R2 disabled engine ignores the bus
        dev_active = 1'b0; cyc(2);
        bus_start();
        send_bits({OWN, 1'b0});
        pulse(s);
        chk("R2 no ack", !s, 0);
        bus_stop();
        chk("R2 no irq", raw, 3'b000);
        chk("R2 no pulls", {scl_pull, sda_pull}, 0);
        dev_active = 1'b1; cyc(2);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule